// File: doc/BRIEF.md
# Interrupt Request and In-Service Status Tracker

This block holds two status words for a small embedded interrupt controller: a pending-request word and an in-service word. Internal sources (a timer group, two DMA-or-pin channels, five general interrupt inputs and two serial ports) raise one-cycle request pulses, which the block latches. When the CPU acknowledges a source, given as a one-cycle strobe with a bit index chosen by an external arbiter, the block moves that source from pending to in service on a single clock edge. Software ends service by writing an end-of-interrupt command that carries an interrupt type code. The block maps that code to a bit and clears it.

Both words can be read on a simple register bus, and neither can be written through it. A mode input chooses between two bit layouts. The master layout covers all ten sources. The slave layout has three separate timers and the two DMA-or-pin channels. Changing the mode wipes both words, so a bit is never read under the wrong layout. Arbitration, vectoring, masking and pin sampling take place outside this block.

Top module: `irq_track`

## Requirements
- R1: After synchronous reset, reads of the in-service word (offset 2Ch) and the request word (offset 2Eh) both return 0000h.
- R2: A request pulse on req_in bit n sets request bit n on the next edge and holds it until it is acknowledged or cleared by a mode change.
- R3: Only layout bits can be set. Master mode (master_mode=1) uses bits 0 and 2 to 10. Slave mode uses bits 0 and 2 to 5. All other bits read zero, and requests on them are ignored.
- R4: An acknowledge strobe with index n clears request bit n and sets in-service bit n on the same edge. An index outside the current layout changes nothing.
- R5: If a request and an acknowledge for the same bit arrive in one cycle, the request bit stays set.
- R6: In master mode, an end-of-interrupt write (offset 22h, type code in data bits 4:0) clears in-service bit 0 for code 8, bit 2 for code 10, bit 3 for code 11, bits 4 to 8 for codes 12 to 16, bit 10 for code 20 and bit 9 for code 21.
- R7: In slave mode, end-of-interrupt codes 8, 10, 11, 18 and 19 clear in-service bits 0, 2, 3, 4 and 5 respectively.
- R8: An end-of-interrupt code that is not mapped in the current mode changes neither word.
- R9: Bus writes to offsets 2Ch and 2Eh change neither word.
- R10: Any change of master_mode clears both words on the next edge, and requests or acknowledges in that cycle are dropped.
- R11: If an acknowledge and an end-of-interrupt for the same bit arrive in one cycle, the in-service bit ends up set.
- R12: Read data and bus_rvalid appear one cycle after bus_rd. Offsets other than 2Ch and 2Eh read 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1 selects the master layout, 0 the slave layout |
| req_in | input | 16 | Request pulses, indexed by status bit position |
| ack_vld | input | 1 | One-cycle acknowledge strobe |
| ack_idx | input | 4 | Bit position of the acknowledged source |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |

## Verification
The tests start with a single request, then an all-ones request that shows which bits each layout accepts. Acknowledges then hit mapped bits and a reserved bit. This separates correct moves from pending to in service from index decode errors. Collision cycles (request with acknowledge, acknowledge with end-of-interrupt) show which update has priority. End-of-interrupt codes are sent in both modes, including codes mapped only in the other mode, to check the code-to-bit tables. Mode toggles and writes to the read-only offsets show that the stored state is wiped only when it should be.

// File: rtl/irq_track_pkg.sv
`timescale 1ns/1ps
package irq_track_pkg;
  localparam int REG_W  = 16;
  localparam int IDX_W  = $clog2(REG_W);
  localparam int TYPE_W = 5;

  localparam logic [REG_W-1:0] MASTER_LANES = 16'h07FD;
  localparam logic [REG_W-1:0] SLAVE_LANES  = 16'h003D;

  localparam logic [TYPE_W-1:0] T_TMR  = 5'd8;
  localparam logic [TYPE_W-1:0] T_CH0  = 5'd10;
  localparam logic [TYPE_W-1:0] T_CH1  = 5'd11;
  localparam logic [TYPE_W-1:0] T_GIN0 = 5'd12;
  localparam logic [TYPE_W-1:0] T_GIN4 = 5'd16;
  localparam logic [TYPE_W-1:0] T_TMB  = 5'd18;
  localparam logic [TYPE_W-1:0] T_TMC  = 5'd19;
  localparam logic [TYPE_W-1:0] T_SER0 = 5'd20;
  localparam logic [TYPE_W-1:0] T_SER1 = 5'd21;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] pos;
  } eoi_map_t;

  function automatic logic [REG_W-1:0] lane_mask(input logic master);
    return master ? MASTER_LANES : SLAVE_LANES;
  endfunction
endpackage

// File: rtl/irq_track_eoi_dec.sv
`timescale 1ns/1ps
module irq_track_eoi_dec
  import irq_track_pkg::*;
#(
  parameter int LANES = REG_W,
  parameter int TW    = TYPE_W
) (
  input  logic             master,
  input  logic             stb,
  input  logic [TW-1:0]    code,
  output logic [LANES-1:0] clr_vec
);
  eoi_map_t m;

  always_comb begin
    m = '0;
    if (master) begin
      if (code == T_TMR)       m = '{hit: 1'b1, pos: IDX_W'(0)};
      else if (code == T_CH0)  m = '{hit: 1'b1, pos: IDX_W'(2)};
      else if (code == T_CH1)  m = '{hit: 1'b1, pos: IDX_W'(3)};
      else if (code >= T_GIN0 && code <= T_GIN4)
        m = '{hit: 1'b1, pos: IDX_W'(code - T_GIN0 + TW'(4))};
      else if (code == T_SER0) m = '{hit: 1'b1, pos: IDX_W'(10)};
      else if (code == T_SER1) m = '{hit: 1'b1, pos: IDX_W'(9)};
    end else begin
      if (code == T_TMR)       m = '{hit: 1'b1, pos: IDX_W'(0)};
      else if (code == T_CH0)  m = '{hit: 1'b1, pos: IDX_W'(2)};
      else if (code == T_CH1)  m = '{hit: 1'b1, pos: IDX_W'(3)};
      else if (code == T_TMB)  m = '{hit: 1'b1, pos: IDX_W'(4)};
      else if (code == T_TMC)  m = '{hit: 1'b1, pos: IDX_W'(5)};
    end
  end

  always_comb begin
    clr_vec = '0;
    if (stb && m.hit) clr_vec[m.pos] = 1'b1;
  end
endmodule

// File: rtl/irq_track_lane.sv
`timescale 1ns/1ps
module irq_track_lane (
  input  logic clk,
  input  logic rst,
  input  logic wipe,
  input  logic live,
  input  logic req,
  input  logic ack,
  input  logic eoi,
  output logic pend_q,
  output logic serv_q
);
  always_ff @(posedge clk) begin
    if (rst || wipe || !live) begin
      pend_q <= 1'b0;
      serv_q <= 1'b0;
    end else begin
      // new request beats acknowledge; acknowledge beats end-of-interrupt
      pend_q <= (pend_q & ~ack) | req;
      serv_q <= (serv_q & ~eoi) | ack;
    end
  end
endmodule

// File: rtl/irq_track_rdport.sv
`timescale 1ns/1ps
module irq_track_rdport #(
  parameter int          DW      = 16,
  parameter int          AW      = 8,
  parameter logic [AW-1:0] SERV_OFF = 8'h2C,
  parameter logic [AW-1:0] PEND_OFF = 8'h2E
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] pend,
  input  logic [DW-1:0] serv,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic [DW-1:0] sel;

  always_comb begin
    if (addr == SERV_OFF)      sel = serv;
    else if (addr == PEND_OFF) sel = pend;
    else                       sel = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= sel;
    end
  end
endmodule

// File: rtl/irq_track.sv
`timescale 1ns/1ps
module irq_track
  import irq_track_pkg::*;
#(
  parameter int            ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] EOI_OFF  = 8'h22,
  parameter logic [ADDR_W-1:0] SERV_OFF = 8'h2C,
  parameter logic [ADDR_W-1:0] PEND_OFF = 8'h2E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_mode,
  input  logic [REG_W-1:0]  req_in,
  input  logic              ack_vld,
  input  logic [IDX_W-1:0]  ack_idx,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              bus_rvalid
);
  logic             mode_q;
  logic             wipe;
  logic [REG_W-1:0] live;
  logic [REG_W-1:0] ack_hot;
  logic [REG_W-1:0] eoi_hot;
  logic [REG_W-1:0] irr_q;
  logic [REG_W-1:0] isr_q;
  logic             eoi_stb;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= master_mode;
    else     mode_q <= master_mode;
  end

  assign wipe    = !rst && (mode_q != master_mode);
  assign live    = lane_mask(master_mode);
  assign ack_hot = ack_vld ? (REG_W'(1) << ack_idx) : '0;
  assign eoi_stb = bus_wr && (bus_addr == EOI_OFF);

  irq_track_eoi_dec #(.LANES(REG_W), .TW(TYPE_W)) u_dec (
    .master  (master_mode),
    .stb     (eoi_stb),
    .code    (bus_wdata[TYPE_W-1:0]),
    .clr_vec (eoi_hot)
  );

  for (genvar g = 0; g < REG_W; g++) begin : g_lane
    irq_track_lane u_lane (
      .clk    (clk),
      .rst    (rst),
      .wipe   (wipe),
      .live   (live[g]),
      .req    (req_in[g]),
      .ack    (ack_hot[g]),
      .eoi    (eoi_hot[g]),
      .pend_q (irr_q[g]),
      .serv_q (isr_q[g])
    );
  end

  irq_track_rdport #(
    .DW(REG_W), .AW(ADDR_W), .SERV_OFF(SERV_OFF), .PEND_OFF(PEND_OFF)
  ) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd     (bus_rd),
    .addr   (bus_addr),
    .pend   (irr_q),
    .serv   (isr_q),
    .rdata  (bus_rdata),
    .rvalid (bus_rvalid)
  );
endmodule

// File: rtl/irq_track_chk.sv
`timescale 1ns/1ps
module irq_track_chk #(
  parameter int          AW      = 8,
  parameter logic [AW-1:0] EOI_OFF = 8'h22
) (
  input logic          clk,
  input logic          rst,
  input logic          master_mode,
  input logic [15:0]   req_in,
  input logic          ack_vld,
  input logic [3:0]    ack_idx,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic [15:0]   bus_wdata,
  input logic          bus_rd,
  input logic          bus_rvalid,
  input logic [15:0]   irr,
  input logic [15:0]   isr
);
  logic [15:0] lanes;
  assign lanes = master_mode ? 16'h07FD : 16'h003D;

  // R3: outside a mode change, nothing outside the layout is set
  p_layout_only_r3: assert property (@(posedge clk) disable iff (rst)
    (master_mode == $past(master_mode)) |-> (((irr | isr) & ~lanes) == 16'h0));

  // R4: acknowledge moves a source into service
  p_ack_sets_serv_r4: assert property (@(posedge clk) disable iff (rst)
    (ack_vld && lanes[ack_idx] && master_mode == $past(master_mode))
      |=> isr[$past(ack_idx)]);

  // R4: acknowledge drops the pending bit when no fresh request
  p_ack_clears_pend_r4: assert property (@(posedge clk) disable iff (rst)
    (ack_vld && lanes[ack_idx] && !req_in[ack_idx] && master_mode == $past(master_mode))
      |=> !irr[$past(ack_idx)]);

  // R5: fresh request survives a same-cycle acknowledge
  p_req_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (ack_vld && lanes[ack_idx] && req_in[ack_idx] && master_mode == $past(master_mode))
      |=> irr[$past(ack_idx)]);

  // R6: timer end-of-interrupt clears bit 0
  p_eoi_timer_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == EOI_OFF && bus_wdata[4:0] == 5'd8 &&
     !(ack_vld && ack_idx == 4'd0) && master_mode == $past(master_mode))
      |=> !isr[0]);

  // R10: mode change wipes both words
  p_mode_wipe_r10: assert property (@(posedge clk) disable iff (rst)
    (master_mode != $past(master_mode)) |=> (irr == 16'h0 && isr == 16'h0));

  // R12: read strobe answered one cycle later
  p_rvalid_r12: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
endmodule

bind irq_track irq_track_chk #(.AW(ADDR_W), .EOI_OFF(EOI_OFF)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .master_mode (master_mode),
  .req_in      (req_in),
  .ack_vld     (ack_vld),
  .ack_idx     (ack_idx),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .bus_rd      (bus_rd),
  .bus_rvalid  (bus_rvalid),
  .irr         (irr_q),
  .isr         (isr_q)
);

// File: tb/irq_track_test.sv
`timescale 1ns/1ps
module irq_track_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        master_mode = 1'b1;
  logic [15:0] req_in = '0;
  logic        ack_vld = 1'b0;
  logic [3:0]  ack_idx = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;

  always #2 clk = ~clk;

  irq_track uut (
    .clk(clk), .rst(rst), .master_mode(master_mode), .req_in(req_in),
    .ack_vld(ack_vld), .ack_idx(ack_idx), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t sb[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [15:0] m_irr = '0, m_isr = '0;

  function automatic logic [15:0] mask_of(input logic m);
    return m ? 16'h07FD : 16'h003D;
  endfunction

  function automatic logic [15:0] eoi_bit(input logic m, input logic [4:0] c);
    if (m) begin
      case (c)
        5'd8: return 16'h0001;  5'd10: return 16'h0004; 5'd11: return 16'h0008;
        5'd12: return 16'h0010; 5'd13: return 16'h0020; 5'd14: return 16'h0040;
        5'd15: return 16'h0080; 5'd16: return 16'h0100;
        5'd20: return 16'h0400; 5'd21: return 16'h0200;
        default: return 16'h0000;
      endcase
    end else begin
      case (c)
        5'd8: return 16'h0001;  5'd10: return 16'h0004; 5'd11: return 16'h0008;
        5'd18: return 16'h0010; 5'd19: return 16'h0020;
        default: return 16'h0000;
      endcase
    end
  endfunction

  // driver: one cycle of stimulus, updates the reference state
  task automatic op(input logic [15:0] rq, input logic av, input logic [3:0] ai,
                    input logic wr, input logic [7:0] a, input logic [15:0] wd);
    logic [15:0] ah, eh;
    @(negedge clk);
    req_in = rq; ack_vld = av; ack_idx = ai;
    bus_wr = wr; bus_addr = a; bus_wdata = wd;
    ah = av ? ((16'h1 << ai) & mask_of(master_mode)) : 16'h0;
    eh = (wr && a == 8'h22) ? eoi_bit(master_mode, wd[4:0]) : 16'h0;
    m_irr = (m_irr & ~ah) | (rq & mask_of(master_mode));
    m_isr = (m_isr & ~eh) | ah;
    @(negedge clk);
    req_in = '0; ack_vld = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    it.exp = (a == 8'h2C) ? m_isr : (a == 8'h2E) ? m_irr : 16'h0;
    it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    master_mode = m;
    m_irr = '0; m_isr = '0;
    @(negedge clk);
  endtask

  // monitor: compares results as they appear
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      item_t it;
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R12 unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        it = sb.pop_front();
        if (bus_rdata !== it.exp) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  initial begin
    #(4 * 50000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd(8'h2C, "R1 in-service after reset");
    rd(8'h2E, "R1 request after reset");
    // master layout
    op(16'h0004, 0, 0, 0, 0, 0);         rd(8'h2E, "R2 single request");
    op(16'hFFFF, 0, 0, 0, 0, 0);         rd(8'h2E, "R3 master layout mask");
    op(0, 1, 4'd2, 0, 0, 0);
    rd(8'h2E, "R4 ack clears request"); rd(8'h2C, "R4 ack sets in-service");
    op(0, 1, 4'd1, 0, 0, 0);
    rd(8'h2C, "R4 reserved ack ignored"); rd(8'h2E, "R4 reserved ack request");
    op(16'h0008, 1, 4'd3, 0, 0, 0);      rd(8'h2E, "R5 request beats ack");
    op(0, 0, 0, 1, 8'h22, 16'd10);       rd(8'h2C, "R6 eoi 10");
    op(0, 1, 4'd10, 0, 0, 0);
    op(0, 1, 4'd9, 0, 0, 0);
    op(0, 1, 4'd8, 0, 0, 0);
    op(0, 0, 0, 1, 8'h22, 16'd21);       rd(8'h2C, "R6 eoi 21 -> bit9");
    op(0, 0, 0, 1, 8'h22, 16'd20);       rd(8'h2C, "R6 eoi 20 -> bit10");
    op(0, 0, 0, 1, 8'h22, 16'd16);       rd(8'h2C, "R6 eoi 16 -> bit8");
    op(0, 1, 4'd4, 0, 0, 0);
    op(0, 0, 0, 1, 8'h22, 16'd17);       rd(8'h2C, "R8 unmapped 17");
    op(0, 0, 0, 1, 8'h22, 16'd18);       rd(8'h2C, "R8 slave-only 18 in master");
    op(0, 0, 0, 1, 8'h2E, 16'hFFFF);     rd(8'h2E, "R9 write to request word");
    op(0, 0, 0, 1, 8'h2C, 16'h0000);     rd(8'h2C, "R9 write to in-service word");
    op(0, 1, 4'd5, 0, 0, 0);
    op(0, 1, 4'd5, 1, 8'h22, 16'd13);    rd(8'h2C, "R11 ack beats eoi");
    op(0, 0, 0, 1, 8'h22, 16'd8);        rd(8'h2C, "R6 eoi 8 -> bit0");
    rd(8'h30, "R12 unmapped offset");
    // slave layout
    set_mode(1'b0);
    rd(8'h2C, "R10 in-service wiped"); rd(8'h2E, "R10 request wiped");
    op(16'hFFFF, 0, 0, 0, 0, 0);         rd(8'h2E, "R3 slave layout mask");
    op(0, 1, 4'd6, 0, 0, 0);             rd(8'h2C, "R4 ack outside slave layout");
    op(0, 1, 4'd4, 0, 0, 0);
    op(0, 1, 4'd5, 0, 0, 0);
    op(0, 1, 4'd0, 0, 0, 0);
    op(0, 1, 4'd3, 0, 0, 0);             rd(8'h2C, "R7 slave in-service set");
    op(0, 0, 0, 1, 8'h22, 16'd18);       rd(8'h2C, "R7 eoi 18 -> bit4");
    op(0, 0, 0, 1, 8'h22, 16'd19);       rd(8'h2C, "R7 eoi 19 -> bit5");
    op(0, 0, 0, 1, 8'h22, 16'd12);       rd(8'h2C, "R8 master-only 12 in slave");
    op(0, 0, 0, 1, 8'h22, 16'd11);       rd(8'h2C, "R7 eoi 11 -> bit3");
    set_mode(1'b1);
    rd(8'h2C, "R10 in-service wiped back"); rd(8'h2E, "R10 request wiped back");
    repeat (4) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R12 missing reads actual=%0d expected=0", sb.size());
    end
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule